// File: doc/BRIEF.md
# Frame Capture Control and Status Registers

This block is the register file that software uses to steer a frame-capture engine. A 32-bit bus slave with a single-cycle handshake holds the configuration the engine consumes: the memory base address for captured data, an 8-bit camera clock divider, the expected frame size in bytes and an interrupt enable. The camera clock that the engine derives from the divider is twice the platform clock divided by (divider + 1); a setting of 3 on a 50 MHz platform gives 25 MHz. The block only stores the setting and passes it on.

Commands are write-only: setting a bit in the command word produces a one-cycle strobe toward the engine (start capture, acknowledge interrupt, soft reset) and nothing is kept. In the other direction, the engine reports its 3-bit state code, which is read back directly, and pulses events (frame start, frame done with its byte count, bus error, FIFO overflow). From these the block keeps three sticky flags and drives a level interrupt.

No data stream passes through this block, so every pin is a plain control or status signal; the bus side has no back-pressure because every access is acknowledged in the cycle it is presented.

Top module: `cam_capture_csr`

## Requirements
- R1: After reset the base address, divider, expected count and interrupt enable are 0, all three flags are 0, the interrupt output is low and no command strobe is active.
- R2: Word offset 0x00 (base address) and 0x18 (expected byte count) are 32-bit read/write; a write is visible on the read port and on the matching configuration output from the next cycle.
- R3: Offset 0x14 holds an 8-bit divider in bits [7:0] and offset 0x10 holds the interrupt enable in bit 0; the remaining bits of both read as 0 and written values there are dropped.
- R4: Offset 0x04 returns the engine state code on bits [2:0] with upper bits 0; writes to offsets 0x04 and 0x08 change nothing.
- R5: A write to offset 0x0C raises start for bit 0, interrupt acknowledge for bit 1 and soft reset for bit 2, each high for exactly the one cycle after the write; the offset reads as 0.
- R6: Flag bit 0 (frame done) sets on a frame-done event and clears on a frame-start event or a command write with bit 1 set; a frame-done event in the same cycle as a clearing cause leaves it set.
- R7: Flag bit 1 (error) sets on a bus-error or FIFO-overflow event and clears on a frame-start event; a setting event in the same cycle as frame start leaves it set.
- R8: Flag bit 2 (size error) sets on a frame-done event whose byte count differs from a non-zero expected count, is left unchanged by any frame when the expected count is 0, and clears on a frame-start event.
- R9: The interrupt output is high exactly when the frame-done flag and the interrupt enable are both 1.
- R10: Every access is acknowledged in the cycle it is presented; offsets 0x1C and above read as 0 and writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cyc | input | 1 | Bus cycle active |
| bus_stb | input | 1 | Bus strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 5 | Byte address within the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| bus_ack | output | 1 | Access acknowledge |
| cap_state | input | 3 | State code of the capture engine |
| ev_frame_start | input | 1 | One-cycle pulse: a new frame begins |
| ev_frame_done | input | 1 | One-cycle pulse: frame fully stored |
| ev_byte_count | input | 32 | Byte count of the finished frame, valid with ev_frame_done |
| ev_bus_err | input | 1 | Bus error seen by the engine's master port |
| ev_fifo_ovf | input | 1 | Engine FIFO overflowed |
| cfg_base_addr | output | 32 | Destination base address |
| cfg_div | output | 8 | Camera clock divider |
| cfg_expect | output | 32 | Expected frame size in bytes, 0 disables the check |
| cmd_start | output | 1 | Start-capture strobe |
| cmd_irq_ack | output | 1 | Interrupt-acknowledge strobe |
| cmd_soft_rst | output | 1 | Soft-reset strobe |
| irq | output | 1 | Level interrupt |

## Verification
A corrupted flag register shows up on the interrupt pin in the very next cycle whenever the enable is set, and on a read of offset 0x08 otherwise, so the bench compares both after every event. A decode fault in the register index shows as a wrong read value or as a configuration output changing after a write to a different offset, visible one cycle after the write. A stuck or stretched command strobe is seen in the cycle after the command write and in the cycle after that. The size check's zero-count bypass only shows after a frame-done event, so the bench drives frames with matching and mismatching counts under both zero and non-zero expectations.

// File: rtl/cam_csr_pkg.sv
package cam_csr_pkg;

  localparam int DATA_W = 32;
  localparam int NUM_REGS = 7;

  typedef enum logic [2:0] {
    IDX_BASE   = 3'd0,
    IDX_STATE  = 3'd1,
    IDX_FLAGS  = 3'd2,
    IDX_CMD    = 3'd3,
    IDX_IEN    = 3'd4,
    IDX_DIV    = 3'd5,
    IDX_EXPECT = 3'd6,
    IDX_NONE   = 3'd7
  } reg_idx_e;

  localparam int FLG_DONE = 0;
  localparam int FLG_ERR  = 1;
  localparam int FLG_SIZE = 2;
  localparam int NUM_FLAGS = 3;

  localparam int CMD_START = 0;
  localparam int CMD_ACK   = 1;
  localparam int CMD_SRST  = 2;
  localparam int NUM_CMDS  = 3;

endpackage

// File: rtl/cam_csr_cfg.sv
module cam_csr_cfg
  import cam_csr_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_idx_e          wr_idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] base_q,
  output logic [DIV_W-1:0]  div_q,
  output logic [CNT_W-1:0]  expect_q,
  output logic              ien_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q   <= '0;
      div_q    <= '0;
      expect_q <= '0;
      ien_q    <= 1'b0;
    end else if (wr_en) begin
      case (wr_idx)
        IDX_BASE:   base_q   <= wdata;
        IDX_DIV:    div_q    <= wdata[DIV_W-1:0];
        IDX_EXPECT: expect_q <= wdata[CNT_W-1:0];
        IDX_IEN:    ien_q    <= wdata[0];
        default:    ;
      endcase
    end
  end

  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_idx == IDX_BASE) |=> $stable(base_q)) else $error("base changed without write"); // R2

  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_idx == IDX_DIV) |=> $stable(div_q)) else $error("divider changed without write"); // R3

endmodule

// File: rtl/cam_csr_cmd.sv
module cam_csr_cmd
  import cam_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_idx_e          wr_idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [NUM_CMDS-1:0] pulse_q
);

  logic cmd_wr;
  assign cmd_wr = wr_en && (wr_idx == IDX_CMD);

  for (genvar i = 0; i < NUM_CMDS; i++) begin : g_strobe
    always_ff @(posedge clk) begin
      if (!rst_n) pulse_q[i] <= 1'b0;
      else        pulse_q[i] <= cmd_wr && wdata[i];
    end

    AST_CMD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q[i] |-> $past(wr_en && wr_idx == IDX_CMD && wdata[i])) else $error("strobe without command"); // R5
  end

endmodule

// File: rtl/cam_csr_flags.sv
module cam_csr_flags
  import cam_csr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_start,
  input  logic                 frame_done,
  input  logic [CNT_W-1:0]     byte_count,
  input  logic                 bus_err,
  input  logic                 fifo_ovf,
  input  logic [CNT_W-1:0]     expect_cnt,
  input  logic                 ack_clr,
  output logic [NUM_FLAGS-1:0] flags_q
);

  logic check_on;
  logic mismatch;
  logic [NUM_FLAGS-1:0] set_ev;
  logic [NUM_FLAGS-1:0] clr_ev;
  logic [NUM_FLAGS-1:0] flags_d;

  assign check_on = |expect_cnt;
  assign mismatch = frame_done && check_on && (byte_count != expect_cnt);

  always_comb begin
    set_ev = '0;
    clr_ev = '0;
    set_ev[FLG_DONE] = frame_done;
    set_ev[FLG_ERR]  = bus_err | fifo_ovf;
    set_ev[FLG_SIZE] = mismatch;
    clr_ev[FLG_DONE] = frame_start | ack_clr;
    clr_ev[FLG_ERR]  = frame_start;
    clr_ev[FLG_SIZE] = frame_start;
  end

  // A setting event wins over a clearing one in the same cycle.
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    assign flags_d[i] = set_ev[i] | (flags_q[i] & ~clr_ev[i]);
    always_ff @(posedge clk) begin
      if (!rst_n) flags_q[i] <= 1'b0;
      else        flags_q[i] <= flags_d[i];
    end
  end

  AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> flags_q[FLG_DONE]) else $error("done flag not set"); // R6

  AST_DONE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !frame_done) |=> !flags_q[FLG_DONE]) else $error("done flag not cleared"); // R6

  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err || fifo_ovf) |=> flags_q[FLG_ERR]) else $error("error flag not set"); // R7

  AST_SIZE_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (expect_cnt == '0 && !frame_start) |=> $stable(flags_q[FLG_SIZE])) else $error("size check not bypassed"); // R8

endmodule

// File: rtl/cam_csr_rdmux.sv
module cam_csr_rdmux
  import cam_csr_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int CNT_W = 32
) (
  input  reg_idx_e              rd_idx,
  input  logic [DATA_W-1:0]     base_q,
  input  logic [2:0]            state_code,
  input  logic [NUM_FLAGS-1:0]  flags_q,
  input  logic                  ien_q,
  input  logic [DIV_W-1:0]      div_q,
  input  logic [CNT_W-1:0]      expect_q,
  output logic [DATA_W-1:0]     rdata
);

  always_comb begin
    rdata = '0;
    case (rd_idx)
      IDX_BASE:   rdata = base_q;
      IDX_STATE:  rdata[2:0] = state_code;
      IDX_FLAGS:  rdata[NUM_FLAGS-1:0] = flags_q;
      IDX_IEN:    rdata[0] = ien_q;
      IDX_DIV:    rdata[DIV_W-1:0] = div_q;
      IDX_EXPECT: rdata[CNT_W-1:0] = expect_q;
      default:    rdata = '0;
    endcase
  end

endmodule

// File: rtl/cam_capture_csr.sv
module cam_capture_csr
  import cam_csr_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DIV_W  = 8,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cyc,
  input  logic              bus_stb,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_ack,
  input  logic [2:0]        cap_state,
  input  logic              ev_frame_start,
  input  logic              ev_frame_done,
  input  logic [CNT_W-1:0]  ev_byte_count,
  input  logic              ev_bus_err,
  input  logic              ev_fifo_ovf,
  output logic [31:0]       cfg_base_addr,
  output logic [DIV_W-1:0]  cfg_div,
  output logic [CNT_W-1:0]  cfg_expect,
  output logic              cmd_start,
  output logic              cmd_irq_ack,
  output logic              cmd_soft_rst,
  output logic              irq
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]       word_idx;
  logic                   in_map;
  logic                   access;
  logic                   wr_en;
  reg_idx_e               sel_idx;
  logic                   ien_q;
  logic [NUM_FLAGS-1:0]   flags_q;
  logic [NUM_CMDS-1:0]    pulses;
  logic                   ack_clr;

  assign word_idx = bus_addr[ADDR_W-1:2];
  assign in_map   = word_idx < IDX_W'(NUM_REGS);
  assign sel_idx  = in_map ? reg_idx_e'(word_idx[2:0]) : IDX_NONE;
  assign access   = bus_cyc && bus_stb;
  assign wr_en    = access && bus_we;
  assign bus_ack  = access;
  assign ack_clr  = wr_en && (sel_idx == IDX_CMD) && bus_wdata[CMD_ACK];

  cam_csr_cfg #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (sel_idx),
    .wdata    (bus_wdata),
    .base_q   (cfg_base_addr),
    .div_q    (cfg_div),
    .expect_q (cfg_expect),
    .ien_q    (ien_q)
  );

  cam_csr_cmd u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (sel_idx),
    .wdata   (bus_wdata),
    .pulse_q (pulses)
  );

  assign cmd_start    = pulses[CMD_START];
  assign cmd_irq_ack  = pulses[CMD_ACK];
  assign cmd_soft_rst = pulses[CMD_SRST];

  cam_csr_flags #(.CNT_W(CNT_W)) u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (ev_frame_start),
    .frame_done  (ev_frame_done),
    .byte_count  (ev_byte_count),
    .bus_err     (ev_bus_err),
    .fifo_ovf    (ev_fifo_ovf),
    .expect_cnt  (cfg_expect),
    .ack_clr     (ack_clr),
    .flags_q     (flags_q)
  );

  cam_csr_rdmux #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_rd (
    .rd_idx     (sel_idx),
    .base_q     (cfg_base_addr),
    .state_code (cap_state),
    .flags_q    (flags_q),
    .ien_q      (ien_q),
    .div_q      (cfg_div),
    .expect_q   (cfg_expect),
    .rdata      (bus_rdata)
  );

  assign irq = flags_q[FLG_DONE] & ien_q;

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ien_q) else $error("irq without enable"); // R9

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_clr && !ev_frame_done) |=> !irq) else $error("irq survived acknowledge"); // R6

endmodule

// File: tb/tb_cam_capture_csr.sv
module tb_cam_capture_csr;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_cyc = 0, bus_stb = 0, bus_we = 0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ack;
  logic [2:0]  cap_state = '0;
  logic        ev_frame_start = 0, ev_frame_done = 0, ev_bus_err = 0, ev_fifo_ovf = 0;
  logic [31:0] ev_byte_count = '0;
  logic [31:0] cfg_base_addr, cfg_expect;
  logic [7:0]  cfg_div;
  logic        cmd_start, cmd_irq_ack, cmd_soft_rst, irq;

  int checks = 0;
  int errors = 0;

  // shadow model
  logic [31:0] m_base = 0, m_expect = 0;
  logic [7:0]  m_div = 0;
  logic        m_ien = 0, m_done = 0, m_err = 0, m_size = 0;

  always #5 clk = ~clk;

  cam_capture_csr dut (
    .clk(clk), .rst_n(rst_n), .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .cap_state(cap_state), .ev_frame_start(ev_frame_start), .ev_frame_done(ev_frame_done),
    .ev_byte_count(ev_byte_count), .ev_bus_err(ev_bus_err), .ev_fifo_ovf(ev_fifo_ovf),
    .cfg_base_addr(cfg_base_addr), .cfg_div(cfg_div), .cfg_expect(cfg_expect),
    .cmd_start(cmd_start), .cmd_irq_ack(cmd_irq_ack), .cmd_soft_rst(cmd_soft_rst), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [4:0] a);
    case (a[4:2])
      3'd0: return m_base;
      3'd1: return {29'd0, cap_state};
      3'd2: return {29'd0, m_size, m_err, m_done};
      3'd4: return {31'd0, m_ien};
      3'd5: return {24'd0, m_div};
      3'd6: return m_expect;
      default: return 32'd0;
    endcase
  endfunction

  function automatic void model_write(input logic [4:0] a, input logic [31:0] d);
    case (a[4:2])
      3'd0: m_base = d;
      3'd4: m_ien = d[0];
      3'd5: m_div = d[7:0];
      3'd6: m_expect = d;
      default: ;
    endcase
  endfunction

  function automatic void model_events(input logic s, input logic dn, input logic be,
                                       input logic ov, input logic [31:0] cnt, input logic ack);
    logic mis;
    mis = dn && (m_expect != 0) && (cnt != m_expect);
    m_done = dn | (m_done & ~(s | ack));
    m_err  = be | ov | (m_err & ~s);
    m_size = mis | (m_size & ~s);
  endfunction

  task automatic check_outputs(input string tag);
    check({tag, " R9 irq"}, {31'd0, irq}, {31'd0, m_done & m_ien});
    check({tag, " R2 base out"}, cfg_base_addr, m_base);
    check({tag, " R2 expect out"}, cfg_expect, m_expect);
    check({tag, " R3 div out"}, {24'd0, cfg_div}, {24'd0, m_div});
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_cyc = 1; bus_stb = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    #1 check("R10 write ack", {31'd0, bus_ack}, 32'd1);
    @(negedge clk);
    bus_cyc = 0; bus_stb = 0; bus_we = 0;
    model_write(a, d);
    if (a[4:2] == 3'd3) model_events(0, 0, 0, 0, 0, d[1]);
  endtask

  task automatic bus_read_check(input logic [4:0] a, input string req);
    @(negedge clk);
    bus_cyc = 1; bus_stb = 1; bus_we = 0; bus_addr = a;
    #1;
    check({req, " read ack"}, {31'd0, bus_ack}, 32'd1);
    check(req, bus_rdata, exp_read(a));
    @(negedge clk);
    bus_cyc = 0; bus_stb = 0;
  endtask

  task automatic events(input logic s, input logic dn, input logic be, input logic ov,
                        input logic [31:0] cnt, input logic ack);
    @(negedge clk);
    ev_frame_start = s; ev_frame_done = dn; ev_bus_err = be; ev_fifo_ovf = ov; ev_byte_count = cnt;
    if (ack) begin
      bus_cyc = 1; bus_stb = 1; bus_we = 1; bus_addr = 5'h0C; bus_wdata = 32'h2;
    end
    @(negedge clk);
    ev_frame_start = 0; ev_frame_done = 0; ev_bus_err = 0; ev_fifo_ovf = 0;
    bus_cyc = 0; bus_stb = 0; bus_we = 0;
    model_events(s, dn, be, ov, cnt, ack);
  endtask

  task automatic cmd_check(input logic [2:0] bits);
    bus_write(5'h0C, {29'h1234567, bits});
    // now in the cycle right after the write edge
    check("R5 start pulse", {31'd0, cmd_start}, {31'd0, bits[0]});
    check("R5 ack pulse", {31'd0, cmd_irq_ack}, {31'd0, bits[1]});
    check("R5 srst pulse", {31'd0, cmd_soft_rst}, {31'd0, bits[2]});
    @(negedge clk);
    check("R5 strobes one cycle", {29'd0, cmd_soft_rst, cmd_irq_ack, cmd_start}, 32'd0);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset values
    check("R1 flags", {29'd0, dut.flags_q}, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 strobes", {29'd0, cmd_soft_rst, cmd_irq_ack, cmd_start}, 32'd0);
    check_outputs("R1");
    for (int a = 0; a < 32; a += 4) bus_read_check(a[4:0], "R1 reset read");

    // R2/R3 directed
    bus_write(5'h00, 32'hDEAD_BEEF); bus_read_check(5'h00, "R2 base rw");
    bus_write(5'h18, 32'h0009_6000); bus_read_check(5'h18, "R2 expect rw");
    bus_write(5'h14, 32'hFFFF_FF03); bus_read_check(5'h14, "R3 div upper zero");
    bus_write(5'h10, 32'hFFFF_FFFE); bus_read_check(5'h10, "R3 ien bit0 only");
    check_outputs("R2R3");
    // R4 state and read-only writes
    cap_state = 3'd5; bus_read_check(5'h04, "R4 state code");
    bus_write(5'h04, 32'hFFFF_FFFF); bus_write(5'h08, 32'hFFFF_FFFF);
    bus_read_check(5'h08, "R4 flags write ignored");
    check_outputs("R4");
    // R10 unmapped
    bus_write(5'h1C, 32'h5555_5555); bus_read_check(5'h1C, "R10 unmapped zero");
    check_outputs("R10");
    // R5 commands
    cmd_check(3'b001); cmd_check(3'b100); cmd_check(3'b111);
    bus_read_check(5'h0C, "R5 cmd reads zero");

    // R6/R9 interrupt flow
    bus_write(5'h10, 32'h1);
    events(0, 1, 0, 0, 32'h0009_6000, 0);
    check_outputs("R9 done irq");
    bus_read_check(5'h08, "R6 done set");
    events(0, 1, 0, 0, 32'h0009_6000, 1); // done beats ack
    bus_read_check(5'h08, "R6 done beats ack");
    bus_write(5'h0C, 32'h2);
    check_outputs("R6 ack clears");
    events(1, 1, 0, 0, 32'h0009_6000, 0); // done beats start
    bus_read_check(5'h08, "R6 done beats start");
    events(1, 0, 0, 0, 0, 0);
    bus_read_check(5'h08, "R6 start clears");
    // R7
    events(0, 0, 1, 0, 0, 0); bus_read_check(5'h08, "R7 bus err");
    events(1, 0, 0, 0, 0, 0); bus_read_check(5'h08, "R7 cleared");
    events(1, 0, 0, 1, 0, 0); bus_read_check(5'h08, "R7 ovf beats start");
    // R8
    events(0, 1, 0, 0, 32'd100, 0); bus_read_check(5'h08, "R8 mismatch");
    events(1, 0, 0, 0, 0, 0);
    bus_write(5'h18, 32'd0);
    events(0, 1, 0, 0, 32'd7, 0); bus_read_check(5'h08, "R8 zero skips");
    bus_write(5'h18, 32'd64);
    events(0, 1, 0, 0, 32'd64, 0); bus_read_check(5'h08, "R8 match clean");

    // constrained random
    for (int it = 0; it < 600; it++) begin
      int op;
      op = $urandom_range(0, 4);
      case (op)
        0: begin
          logic [4:0] a;
          a = 5'($urandom_range(0, 7) * 4);
          if (a == 5'h0C) a = 5'h18;
          if (a == 5'h18) bus_write(a, ($urandom_range(0, 2) == 0) ? 32'd0 : 32'($urandom_range(1, 4)));
          else bus_write(a, $urandom);
        end
        1: begin
          logic [31:0] c;
          c = ($urandom_range(0, 1) == 0) ? m_expect : 32'($urandom_range(0, 4));
          events(($urandom_range(0, 3) == 0), $urandom_range(0, 1) == 1,
                 ($urandom_range(0, 5) == 0), ($urandom_range(0, 5) == 0), c,
                 ($urandom_range(0, 3) == 0));
        end
        2: bus_read_check(5'($urandom_range(0, 7) * 4), "R2 R3 R4 R6 R7 R8 R10 random read");
        3: cmd_check(3'($urandom_range(0, 7)));
        default: cap_state = 3'($urandom_range(0, 5));
      endcase
      check_outputs("rand");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule